// File: doc/BRIEF.md
# Armed SPI Master with Level Handshake

This block is an SPI master run from a four-word register window on a simple 32-bit register bus. Software writes the word to send, then sets an arm bit. The master pulls its active-low select, runs exactly one transfer of a fixed word length and captures the word shifted in from the slave. When the transfer ends and arm is still set, it raises a finished flag. Software clears arm to drop finished and to free the master for the next transfer.

Parameters fix the clock idle level and the sampling edge. The sampling edge is named relative to the rising edge of SCK, not to the first edge of a pulse. Parameters also fix the number of system cycles per SCK half period, the number of cycles between select falling and the first SCK edge (used again after the last edge), the word width, and whether the MOSI and MISO lanes are in use. A device that needs an active-high convert strobe takes the inverse of `ssN`.

Top module: `armed_spi_master`

## Requirements
- R1: After reset, `ssN` is 1, `sck` equals `SCK_POL`, and reads return 0 for the finished flag, the arm bit and the received word.
- R2: The window is decoded by `regAddr[3:2]`, and `regAddr[1:0]` is ignored. Word 0 holds the finished flag in bit 0 and is read-only. Word 1 holds the arm bit in bit 0 and can be read and written. Word 2 holds the received word in bits `WORD_W-1:0` and is read-only. Word 3 holds the transmit word in bits `WORD_W-1:0` and can be read and written. A write to a read-only word changes nothing.
- R3: A transfer holds `ssN` low for exactly `2*SEL_WAIT + 2*WORD_W*HALF_WAIT` clock cycles, with `2*WORD_W` SCK edges spaced `HALF_WAIT` cycles apart. `sck` sits at `SCK_POL` whenever `ssN` is high.
- R4: Once a transfer has begun, writes to the arm bit do not stop, shorten or repeat it. Exactly one transfer runs, and the received word is updated.
- R5: If arm is 1 when a transfer ends, the finished flag becomes 1 and stays 1 while arm stays 1, and no new transfer starts. Writing arm to 0 clears the flag at once. The flag is never 1 while arm is 0.
- R6: If arm is 0 when a transfer ends, the flag stays 0 and the master returns to idle. A later write of arm to 1 starts a new transfer.
- R7: The transmit word is captured when the transfer starts. A write to the transmit word during a transfer does not change the bits sent, and it is read back afterwards.
- R8: Bits go out and come in MSB first. With `SCK_PHASE` 0, MISO is sampled on rising SCK edges; with `SCK_PHASE` 1, on falling edges. MOSI changes only on the other edge, and the first bit is valid from the fall of `ssN`.
- R9: With `USE_MOSI` 0, `mosi` stays 0 at all times.
- R10: With `USE_MISO` 0, the received word keeps its value (0 after reset) across transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| regAddr | input | 4 | Byte address within the register window |
| regWe | input | 1 | Write strobe for the addressed word |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr`, combinational |
| miso | input | 1 | Serial data from the slave |
| mosi | output | 1 | Serial data to the slave |
| sck | output | 1 | Serial clock |
| ssN | output | 1 | Slave select, active low |

## Verification
The bench builds three copies of the block, each against its own slave model.

- The first uses the defaults: idle-low clock, falling-edge sampling, 10-cycle half periods, 5 cycles of select lead, 24-bit words and both lanes. It carries the handshake, the arm-toggling, the read-only-word and the transmit-snapshot cases.
- The second uses an idle-high clock, rising-edge sampling, 5-cycle half periods, 60 cycles of select lead, 18-bit words and MOSI disabled. It shows the data line held low while a full word is received.
- The third uses an idle-low clock, rising-edge sampling, very short waits, 8-bit words and MISO disabled. It covers sampling on the leading edge and a received word that never moves.

// File: rtl/spi_arm_pkg.sv
package spi_arm_pkg;

  // Word slots of the register window, selected by regAddr[3:2].
  typedef enum logic [1:0] {
    SLOT_FLAG = 2'd0,
    SLOT_ARM  = 2'd1,
    SLOT_RX   = 2'd2,
    SLOT_TX   = 2'd3
  } regSlot_t;

  // Sequencer states.
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_CLOCK = 3'd2,
    ST_HOLD  = 3'd3,
    ST_DONE  = 3'd4
  } seqState_t;

  // Strobes sent from the control to the datapath.
  typedef struct packed {
    logic loadTx;
    logic shiftTx;
    logic sampleRx;
  } spiStrobes_t;

endpackage

// File: rtl/spi_arm_regs.sv
module spi_arm_regs
  import spi_arm_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        regAddr,
  input  logic              regWe,
  input  logic [31:0]       regWdata,
  input  logic              finished,
  input  logic [WORD_W-1:0] rxWord,
  output logic              armBit,
  output logic [WORD_W-1:0] txWord,
  output logic [31:0]       regRdata
);

  regSlot_t slotSel;
  assign slotSel = regSlot_t'(regAddr[3:2]);

  // Only the arm and transmit slots hold state written from the bus.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      armBit <= 1'b0;
      txWord <= '0;
    end else if (regWe) begin
      case (slotSel)
        SLOT_ARM: armBit <= regWdata[0];
        SLOT_TX:  txWord <= regWdata[WORD_W-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (slotSel)
      SLOT_FLAG: regRdata = 32'(finished);
      SLOT_ARM:  regRdata = 32'(armBit);
      SLOT_RX:   regRdata = 32'(rxWord);
      default:   regRdata = 32'(txWord);
    endcase
  end

  logic unusedBusBits;
  assign unusedBusBits = ^{regAddr[1:0], regWdata};

endmodule

// File: rtl/spi_arm_ctrl.sv
module spi_arm_ctrl
  import spi_arm_pkg::*;
#(
  parameter bit SCK_POL   = 1'b0,
  parameter bit SCK_PHASE = 1'b1,
  parameter int HALF_WAIT = 10,
  parameter int SEL_WAIT  = 5,
  parameter int WORD_W    = 24
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        armBit,
  output spiStrobes_t strobes,
  output logic        sck,
  output logic        ssN,
  output logic        finished
);

  localparam int EDGES   = 2 * WORD_W;
  localparam int EDGE_W  = $clog2(EDGES + 1);
  localparam int CNT_MAX = (HALF_WAIT > SEL_WAIT) ? HALF_WAIT : SEL_WAIT;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  // Sampling falls on the first edge of each pulse when the idle level
  // and the phase select the same rising/falling edge.
  localparam bit SAMPLE_LEAD = (SCK_POL == SCK_PHASE);

  seqState_t   state;
  logic [CNT_W-1:0]  waitCnt;
  logic [EDGE_W-1:0] edgeCnt;
  logic        sckReg;

  logic selDone;
  logic halfDone;
  logic lastEdge;
  logic leadEdge;

  assign selDone  = (waitCnt == CNT_W'(SEL_WAIT - 1));
  assign halfDone = (state == ST_CLOCK) && (waitCnt == CNT_W'(HALF_WAIT - 1));
  assign lastEdge = (edgeCnt == EDGE_W'(EDGES - 1));
  assign leadEdge = ~edgeCnt[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      edgeCnt <= '0;
      sckReg  <= SCK_POL;
    end else begin
      case (state)
        ST_IDLE: begin
          waitCnt <= '0;
          edgeCnt <= '0;
          if (armBit) state <= ST_SETUP;
        end
        ST_SETUP: begin
          if (selDone) begin
            waitCnt <= '0;
            state   <= ST_CLOCK;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        ST_CLOCK: begin
          if (halfDone) begin
            waitCnt <= '0;
            sckReg  <= ~sckReg;
            edgeCnt <= edgeCnt + 1'b1;
            if (lastEdge) state <= ST_HOLD;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        ST_HOLD: begin
          if (selDone) begin
            waitCnt <= '0;
            state   <= armBit ? ST_DONE : ST_IDLE;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        ST_DONE: begin
          if (!armBit) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.loadTx   = (state == ST_IDLE) && armBit;
    strobes.sampleRx = halfDone && (leadEdge == SAMPLE_LEAD);
    // The first bit is already on the line when select falls, so the very
    // first edge never shifts.
    strobes.shiftTx  = halfDone && (leadEdge != SAMPLE_LEAD) && (edgeCnt != '0);
  end

  assign sck      = sckReg;
  assign ssN      = (state == ST_IDLE) || (state == ST_DONE);
  assign finished = (state == ST_DONE) && armBit;

endmodule

// File: rtl/spi_arm_datapath.sv
module spi_arm_datapath
  import spi_arm_pkg::*;
#(
  parameter int WORD_W   = 24,
  parameter bit USE_MOSI = 1'b1,
  parameter bit USE_MISO = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiStrobes_t       strobes,
  input  logic [WORD_W-1:0] txWord,
  input  logic              miso,
  output logic              mosi,
  output logic [WORD_W-1:0] rxWord
);

  generate
    if (USE_MOSI) begin : g_txLane
      logic [WORD_W-1:0] txShift;
      always_ff @(posedge clk) begin
        if (!rstN)                txShift <= '0;
        else if (strobes.loadTx)  txShift <= txWord;
        else if (strobes.shiftTx) txShift <= txShift << 1;
      end
      assign mosi = txShift[WORD_W-1];
    end else begin : g_noTxLane
      logic unusedTxSide;
      assign unusedTxSide = ^{txWord, strobes.loadTx, strobes.shiftTx};
      assign mosi = 1'b0;
    end

    if (USE_MISO) begin : g_rxLane
      logic [WORD_W-1:0] rxShift;
      always_ff @(posedge clk) begin
        if (!rstN)                 rxShift <= '0;
        else if (strobes.sampleRx) rxShift <= WORD_W'({rxShift, miso});
      end
      assign rxWord = rxShift;
    end else begin : g_noRxLane
      logic unusedRxSide;
      assign unusedRxSide = ^{miso, strobes.sampleRx, clk, rstN};
      assign rxWord = '0;
    end
  endgenerate

endmodule

// File: rtl/armed_spi_master.sv
module armed_spi_master
  import spi_arm_pkg::*;
#(
  parameter bit SCK_POL   = 1'b0,
  parameter bit SCK_PHASE = 1'b1,
  parameter int HALF_WAIT = 10,
  parameter int SEL_WAIT  = 5,
  parameter int WORD_W    = 24,
  parameter bit USE_MOSI  = 1'b1,
  parameter bit USE_MISO  = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  regAddr,
  input  logic        regWe,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic        miso,
  output logic        mosi,
  output logic        sck,
  output logic        ssN
);

  logic              armBit;
  logic              finished;
  logic [WORD_W-1:0] txWord;
  logic [WORD_W-1:0] rxWord;
  spiStrobes_t       strobes;

  spi_arm_regs #(.WORD_W(WORD_W)) regsInst (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWe    (regWe),
    .regWdata (regWdata),
    .finished (finished),
    .rxWord   (rxWord),
    .armBit   (armBit),
    .txWord   (txWord),
    .regRdata (regRdata)
  );

  spi_arm_ctrl #(
    .SCK_POL   (SCK_POL),
    .SCK_PHASE (SCK_PHASE),
    .HALF_WAIT (HALF_WAIT),
    .SEL_WAIT  (SEL_WAIT),
    .WORD_W    (WORD_W)
  ) ctrlInst (
    .clk      (clk),
    .rstN     (rstN),
    .armBit   (armBit),
    .strobes  (strobes),
    .sck      (sck),
    .ssN      (ssN),
    .finished (finished)
  );

  spi_arm_datapath #(
    .WORD_W   (WORD_W),
    .USE_MOSI (USE_MOSI),
    .USE_MISO (USE_MISO)
  ) dpInst (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .txWord  (txWord),
    .miso    (miso),
    .mosi    (mosi),
    .rxWord  (rxWord)
  );

endmodule

// File: rtl/armed_spi_master_chk.sv
module armed_spi_master_chk #(
  parameter bit SCK_POL  = 1'b0,
  parameter bit USE_MOSI = 1'b1
) (
  input logic clk,
  input logic rstN,
  input logic sck,
  input logic ssN,
  input logic mosi,
  input logic armBit,
  input logic finished
);

  // R3
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ssN |-> (sck == SCK_POL));

  // R3
  sck_inside_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sck) |-> !ssN);

  // R4
  start_needs_arm_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ssN) |-> $past(armBit));

  // R5
  finished_needs_arm_chk: assert property (@(posedge clk) disable iff (!rstN)
    finished |-> armBit);

  // R5
  finish_at_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(finished) |-> $rose(ssN));

  generate
    if (!USE_MOSI) begin : g_quietLine
      // R9
      mosi_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
        !ssN |-> (mosi == 1'b0));
    end
  endgenerate

endmodule

bind armed_spi_master armed_spi_master_chk #(
  .SCK_POL  (SCK_POL),
  .USE_MOSI (USE_MOSI)
) chkInst (
  .clk      (clk),
  .rstN     (rstN),
  .sck      (sck),
  .ssN      (ssN),
  .mosi     (mosi),
  .armBit   (armBit),
  .finished (finished)
);

// File: tb/armed_spi_master_test.sv
module spi_slave_model #(
  parameter bit SCK_PHASE = 1'b1,
  parameter int W         = 24
) (
  input  logic        sck,
  input  logic        ssN,
  input  logic        mosi,
  input  logic [31:0] loadWord,
  output logic        miso,
  output logic [31:0] lastGot,
  output int          lastEdges
);
  logic [W-1:0] shreg = '0;
  logic [31:0]  got = '0;
  int           bitCnt = 0;
  int           edges = 0;
  logic         prevSck = 1'b0;

  initial begin
    lastGot = '0;
    lastEdges = 0;
  end

  always @(sck or ssN or loadWord) begin
    if (ssN !== 1'b0) begin
      if (edges != 0) begin
        lastGot = got;
        lastEdges = edges;
      end
      edges = 0;
      bitCnt = 0;
      shreg = loadWord[W-1:0];
      prevSck = sck;
    end else if (sck !== prevSck) begin
      prevSck = sck;
      edges++;
      if ((sck == 1'b1) == (SCK_PHASE == 1'b0)) begin
        got = (bitCnt == 0) ? {31'b0, mosi} : {got[30:0], mosi};
        bitCnt++;
      end else if (bitCnt > 0) begin
        shreg = shreg << 1;
      end
    end
    miso = shreg[W-1];
  end
endmodule

module armed_spi_master_test;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    int          idx;
    logic [31:0] mosiExp;
    string       tag;
  } sbItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic        regWe [3];
  logic [31:0] rdata [3];
  logic        misoArr [3];
  logic        mosiArr [3];
  logic        sckArr [3];
  logic        ssArr [3];
  logic [31:0] slaveWord [3];
  logic [31:0] gotArr [3];
  int          edgeArr [3];

  int checks = 0;
  int errors = 0;
  int doneCnt = 0;
  logic mosiBSeenHigh = 1'b0;
  sbItem_t sbQ [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  armed_spi_master uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe[0]),
    .regWdata(regWdata), .regRdata(rdata[0]), .miso(misoArr[0]),
    .mosi(mosiArr[0]), .sck(sckArr[0]), .ssN(ssArr[0]));

  armed_spi_master #(.SCK_POL(1'b1), .SCK_PHASE(1'b0), .HALF_WAIT(5),
    .SEL_WAIT(60), .WORD_W(18), .USE_MOSI(1'b0), .USE_MISO(1'b1)) uutB (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe[1]),
    .regWdata(regWdata), .regRdata(rdata[1]), .miso(misoArr[1]),
    .mosi(mosiArr[1]), .sck(sckArr[1]), .ssN(ssArr[1]));

  armed_spi_master #(.SCK_POL(1'b0), .SCK_PHASE(1'b0), .HALF_WAIT(2),
    .SEL_WAIT(1), .WORD_W(8), .USE_MOSI(1'b1), .USE_MISO(1'b0)) uutC (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe[2]),
    .regWdata(regWdata), .regRdata(rdata[2]), .miso(misoArr[2]),
    .mosi(mosiArr[2]), .sck(sckArr[2]), .ssN(ssArr[2]));

  spi_slave_model #(.SCK_PHASE(1'b1), .W(24)) slaveA (
    .sck(sckArr[0]), .ssN(ssArr[0]), .mosi(mosiArr[0]), .loadWord(slaveWord[0]),
    .miso(misoArr[0]), .lastGot(gotArr[0]), .lastEdges(edgeArr[0]));
  spi_slave_model #(.SCK_PHASE(1'b0), .W(18)) slaveB (
    .sck(sckArr[1]), .ssN(ssArr[1]), .mosi(mosiArr[1]), .loadWord(slaveWord[1]),
    .miso(misoArr[1]), .lastGot(gotArr[1]), .lastEdges(edgeArr[1]));
  spi_slave_model #(.SCK_PHASE(1'b0), .W(8)) slaveC (
    .sck(sckArr[2]), .ssN(ssArr[2]), .mosi(mosiArr[2]), .loadWord(slaveWord[2]),
    .miso(misoArr[2]), .lastGot(gotArr[2]), .lastEdges(edgeArr[2]));

  always @(negedge clk) if (rstN && mosiArr[1] !== 1'b0) mosiBSeenHigh = 1'b1;

  // Expected frame shape per instance, from R3: 2*SEL + 2*W*HALF cycles low.
  function automatic int lowExp(input int idx);
    case (idx)
      0: return 2*5 + 2*24*10;
      1: return 2*60 + 2*18*5;
      default: return 2*1 + 2*8*2;
    endcase
  endfunction

  function automatic int edgesExp(input int idx);
    case (idx)
      0: return 48;
      1: return 36;
      default: return 16;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input int idx, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    regWdata = d;
    regWe[idx] = 1'b1;
    @(negedge clk);
    regWe[idx] = 1'b0;
  endtask

  task automatic readReg(input int idx, input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1;
    d = rdata[idx];
  endtask

  task automatic pushItem(input int idx, input logic [31:0] mosiWord, input string tag);
    sbItem_t it;
    it.idx = idx;
    it.mosiExp = mosiWord;
    it.tag = tag;
    sbQ.push_back(it);
  endtask

  task automatic waitDone(input int prev);
    while (doneCnt == prev) @(negedge clk);
  endtask

  task automatic monitor(input int idx);
    int n;
    sbItem_t it;
    forever begin
      @(negedge clk);
      if (rstN && ssArr[idx] === 1'b0) begin
        n = 1;
        while (1) begin
          @(negedge clk);
          if (ssArr[idx] !== 1'b0) break;
          n++;
        end
        if (sbQ.size() == 0) begin
          checks++;
          errors++;
          $display("FAIL R4: unexpected transfer on instance %0d, actual 1 expected 0", idx);
        end else begin
          it = sbQ.pop_front();
          check("R4 transfer on expected instance", 32'(idx), 32'(it.idx));
          check("R3 select low cycles", 32'(n), 32'(lowExp(idx)));
          check("R3 sck edge count", 32'(edgeArr[idx]), 32'(edgesExp(idx)));
          check(it.tag, gotArr[idx], it.mosiExp);
        end
        doneCnt++;
      end
    end
  endtask

  initial begin
    fork
      monitor(0);
      monitor(1);
      monitor(2);
    join_none
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int prev;
    regWe = '{default: 1'b0};
    slaveWord = '{default: 32'h0};
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state on every instance
    for (int i = 0; i < 3; i++) begin
      readReg(i, 4'h0, rd); check("R1 finished after reset", rd, 32'h0);
      readReg(i, 4'h4, rd); check("R1 arm after reset", rd, 32'h0);
      readReg(i, 4'h8, rd); check("R1 rx after reset", rd, 32'h0);
      check("R1 ssN idle", 32'(ssArr[i]), 32'h1);
      check("R1 sck idle level", 32'(sckArr[i]), (i == 1) ? 32'h1 : 32'h0);
    end

    // R2 register window decode
    writeReg(0, 4'hC, 32'hFFABCDEF);
    readReg(0, 4'hC, rd); check("R2 tx readback", rd, 32'h00ABCDEF);
    readReg(0, 4'hE, rd); check("R2 low address bits ignored", rd, 32'h00ABCDEF);
    prev = doneCnt;
    writeReg(0, 4'h0, 32'hFFFFFFFF);
    writeReg(0, 4'h8, 32'hFFFFFFFF);
    repeat (20) @(negedge clk);
    readReg(0, 4'h0, rd); check("R2 flag is read-only", rd, 32'h0);
    readReg(0, 4'h8, rd); check("R2 rx is read-only", rd, 32'h0);
    check("R2 read-only writes start nothing", 32'(ssArr[0]), 32'h1);

    // R8 R5 basic transfer on the default build
    slaveWord[0] = 32'h5A3C96;
    writeReg(0, 4'hC, 32'hC3A5F1);
    pushItem(0, 32'hC3A5F1, "R8 mosi word MSB first");
    prev = doneCnt;
    writeReg(0, 4'h4, 32'h1);
    waitDone(prev);
    readReg(0, 4'h0, rd); check("R5 finished with arm high", rd, 32'h1);
    readReg(0, 4'h8, rd); check("R8 received word", rd, 32'h5A3C96);
    repeat (60) @(negedge clk);
    check("R5 no second transfer while armed", 32'(doneCnt), 32'(prev + 1));
    readReg(0, 4'h0, rd); check("R5 finished holds", rd, 32'h1);
    writeReg(0, 4'h4, 32'h0);
    readReg(0, 4'h0, rd); check("R5 finished clears with arm", rd, 32'h0);

    // R4 R6 arm toggled during a transfer, low at the end
    slaveWord[0] = 32'h1E2D3C;
    writeReg(0, 4'hC, 32'h00FF00);
    pushItem(0, 32'h00FF00, "R4 mosi word with arm toggling");
    prev = doneCnt;
    writeReg(0, 4'h4, 32'h1);
    repeat (100) @(negedge clk);
    writeReg(0, 4'h4, 32'h0);
    repeat (50) @(negedge clk);
    writeReg(0, 4'h4, 32'h1);
    repeat (50) @(negedge clk);
    writeReg(0, 4'h4, 32'h0);
    waitDone(prev);
    readReg(0, 4'h0, rd); check("R6 finished stays low", rd, 32'h0);
    readReg(0, 4'h8, rd); check("R4 transfer ran to completion", rd, 32'h1E2D3C);
    repeat (100) @(negedge clk);
    check("R4 exactly one transfer", 32'(doneCnt), 32'(prev + 1));

    // R7 R6 transmit snapshot, new start from idle
    slaveWord[0] = 32'h0F0F0F;
    writeReg(0, 4'hC, 32'h123456);
    pushItem(0, 32'h123456, "R7 mosi word snapshot");
    prev = doneCnt;
    writeReg(0, 4'h4, 32'h1);
    repeat (50) @(negedge clk);
    writeReg(0, 4'hC, 32'hFFFFFF);
    waitDone(prev);
    check("R6 restart after idle", 32'(doneCnt), 32'(prev + 1));
    readReg(0, 4'hC, rd); check("R7 new tx readback", rd, 32'hFFFFFF);
    readReg(0, 4'h8, rd); check("R8 second received word", rd, 32'h0F0F0F);
    writeReg(0, 4'h4, 32'h0);

    // R9 R8 MOSI disabled, idle-high clock, rising-edge sampling
    slaveWord[1] = 32'h2B5A7;
    writeReg(1, 4'hC, 32'h3FFFF);
    pushItem(1, 32'h0, "R9 mosi held low");
    prev = doneCnt;
    writeReg(1, 4'h4, 32'h1);
    waitDone(prev);
    check("R9 mosi never high", 32'(mosiBSeenHigh), 32'h0);
    readReg(1, 4'h8, rd); check("R8 rx rising-edge sample", rd, 32'h2B5A7);
    readReg(1, 4'h0, rd); check("R5 finished on second build", rd, 32'h1);
    writeReg(1, 4'h4, 32'h0);

    // R10 R8 MISO disabled, leading-edge sampling
    slaveWord[2] = 32'hFF;
    writeReg(2, 4'hC, 32'h96);
    pushItem(2, 32'h96, "R8 mosi word leading-edge sample");
    prev = doneCnt;
    writeReg(2, 4'h4, 32'h1);
    waitDone(prev);
    readReg(2, 4'h8, rd); check("R10 rx keeps value", rd, 32'h0);
    writeReg(2, 4'h4, 32'h0);
    writeReg(2, 4'hC, 32'h3C);
    pushItem(2, 32'h3C, "R8 mosi second word");
    prev = doneCnt;
    writeReg(2, 4'h4, 32'h1);
    waitDone(prev);
    readReg(2, 4'h8, rd); check("R10 rx still unchanged", rd, 32'h0);
    writeReg(2, 4'h4, 32'h0);

    repeat (10) @(negedge clk);
    check("R4 scoreboard drained", 32'(sbQ.size()), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule